// File: doc/BRIEF.md
# Retro Computer System Address Decoder

This block splits the 64 KB address space of an 8-bit CPU into chip selects. The selects cover main RAM, screen RAM, the expansion ROM sockets, the BASIC ROM, the editor ROM, the kernel ROM and four memory-mapped peripherals. The memory-region selects come from a purely combinational decode of the address and the write strobe. Writes into ROM space raise no select at all. Parameters set four things:

- how much RAM is installed;
- how large the screen RAM is;
- whether the I/O window spans 2 KB or only its first page;
- whether a video controller is fitted.

The peripherals are picked by single raw address bits inside the I/O window, so several of them can answer one access. When that happens, the read data of every selected peripheral is ANDed together, the way open-drain bus drivers would combine. The peripherals are modelled inside the block as small register-file stubs:

- three 16-byte port/timer chips;
- one video controller with an index register and a data register.

For the memory regions the block passes the external memory byte through. Where nothing drives the bus, it returns 0xFF.

Top module: `addr_decoder`

## Requirements
- R1: Memory-region selects follow the map: RAM 0x0000-0x7FFF, screen 0x8000-0x8FFF, expansion ROM 0x9000-0xBFFF, BASIC ROM 0xC000-0xDFFF, editor ROM 0xE000-0xE7FF, kernel ROM 0xF000-0xFFFF, I/O window 0xE800-0xEFFF. At most one memory-region select is high at a time.
- R2: `cs_ram` is high only below RAM_KB*1024. A read of 0x0000-0x7FFF at or above that limit raises no select and returns 0xFF.
- R3: `scr_addr` is the address modulo SCREEN_KB*1024, so 1 KB of screen RAM repeats four times in the window and 2 KB repeats twice.
- R4: Inside the I/O window, A4 selects port chip 0, A5 selects port chip 1, A6 selects the timer chip and A7 selects the video controller. Each select is independent of the others.
- R5: When several peripheral selects are high on a read, `rdata` is the bitwise AND of their output bytes.
- R6: A read in the I/O window with no peripheral selected returns 0xFF.
- R7: With IO_PAGE_ONLY=1, only 0xE800-0xE8FF is I/O and 0xE900-0xEFFF selects the editor ROM. With IO_PAGE_ONLY=0, the whole window is I/O and address bits A8-A10 are ignored.
- R8: A write (`wr`=1) to any ROM region raises no select.
- R9: Each port/timer stub holds 16 bytes addressed by A3-A0. All bytes reset to 0x00, and a write to an address is read back from any address that selects the same chip and register.
- R10: The video stub decodes A0 only. A0=0 is the index register, which reads back as the 5-bit index. A0=1 is the data register, which accesses entry `index` of 32. With HAS_VIDEO=0, `cs_vid` never rises.
- R11: A read that selects a memory region returns `mem_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the peripheral stubs |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | CPU address |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data |
| mem_rdata | input | 8 | Read data from RAM and ROM |
| rdata | output | 8 | Read data to the CPU |
| cs_ram | output | 1 | Main RAM select |
| cs_scr | output | 1 | Screen RAM select |
| cs_exp | output | 1 | Expansion ROM select |
| cs_basic | output | 1 | BASIC ROM select |
| cs_edit | output | 1 | Editor ROM select |
| cs_kern | output | 1 | Kernel ROM select |
| cs_port0 | output | 1 | Port chip 0 select |
| cs_port1 | output | 1 | Port chip 1 select |
| cs_tmr | output | 1 | Timer chip select |
| cs_vid | output | 1 | Video controller select |
| ram_addr | output | 15 | RAM address |
| scr_addr | output | 12 | Mirrored screen RAM address |

## Verification
The bench builds two copies of the block.

The first copy uses 16 KB RAM, 1 KB screen, a page-only I/O window and a video controller. It reaches the RAM hole above 0x4000, the four-fold screen mirror, the editor ROM at 0xE900 and the video registers.

The second copy uses 32 KB RAM, 2 KB screen, the full I/O window and no video controller. It shows the top RAM byte being selected, the two-fold screen mirror, port registers repeating across 0xE900-0xEFFF, and an open-bus 0xFF where the absent controller would sit.

// File: rtl/addr_decoder.sv
module addr_decoder #(
  parameter int RAM_KB       = 32,
  parameter int SCREEN_KB    = 1,
  parameter bit IO_PAGE_ONLY = 1'b1,
  parameter bit HAS_VIDEO    = 1'b1,
  parameter int PORT_REGS    = 16,
  parameter int VID_REGS     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic [7:0]  wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  rdata,
  output logic        cs_ram,
  output logic        cs_scr,
  output logic        cs_exp,
  output logic        cs_basic,
  output logic        cs_edit,
  output logic        cs_kern,
  output logic        cs_port0,
  output logic        cs_port1,
  output logic        cs_tmr,
  output logic        cs_vid,
  output logic [14:0] ram_addr,
  output logic [11:0] scr_addr
);

  localparam logic [16:0] RAM_TOP  = 17'(RAM_KB * 1024);
  localparam logic [11:0] SCR_MASK = 12'(SCREEN_KB * 1024 - 1);
  localparam int          PAW      = $clog2(PORT_REGS);
  localparam int          VAW      = $clog2(VID_REGS);

  logic io_win, ed_win, rom_ok, ram_hole;
  logic [3:0] psel;

  assign rom_ok = ~wr;
  assign io_win = (addr[15:11] == 5'b11101) && (!IO_PAGE_ONLY || addr[10:8] == 3'b000);
  assign ed_win = (addr[15:11] == 5'b11100) || (addr[15:11] == 5'b11101 && !io_win);

  assign cs_ram   = ~addr[15] && ({1'b0, addr} < RAM_TOP);
  assign ram_hole = ~addr[15] && !cs_ram;
  assign cs_scr   = addr[15:12] == 4'h8;
  assign cs_exp   = rom_ok && (addr[15:12] == 4'h9 || addr[15:13] == 3'b101);
  assign cs_basic = rom_ok && addr[15:13] == 3'b110;
  assign cs_edit  = rom_ok && ed_win;
  assign cs_kern  = rom_ok && addr[15:12] == 4'hF;

  assign psel     = {addr[7] & HAS_VIDEO, addr[6], addr[5], addr[4]} & {4{io_win}};
  assign cs_port0 = psel[0];
  assign cs_port1 = psel[1];
  assign cs_tmr   = psel[2];
  assign cs_vid   = psel[3];

  assign ram_addr = addr[14:0];
  assign scr_addr = addr[11:0] & SCR_MASK;

  logic [7:0] preg [3][PORT_REGS];
  logic [7:0] pdat [4];

  for (genvar k = 0; k < 3; k++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < PORT_REGS; i++) preg[k][i] <= 8'h00;
      end else if (wr && psel[k]) begin
        preg[k][addr[PAW-1:0]] <= wdata;
      end
    end
    assign pdat[k] = preg[k][addr[PAW-1:0]];
  end

  logic [VAW-1:0] vidx;
  logic [7:0]     vreg [VID_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vidx <= '0;
      for (int i = 0; i < VID_REGS; i++) vreg[i] <= 8'h00;
    end else if (wr && psel[3]) begin
      if (addr[0]) vreg[vidx] <= wdata;
      else         vidx <= wdata[VAW-1:0];
    end
  end

  assign pdat[3] = addr[0] ? vreg[vidx] : 8'(vidx);

  logic [7:0] merged;
  always_comb begin
    merged = 8'hFF;
    for (int k = 0; k < 4; k++)
      if (psel[k]) merged = merged & pdat[k];
  end

  assign rdata = (|psel)                          ? merged :
                 (ram_hole || (io_win && !(|psel))) ? 8'hFF  : mem_rdata;

endmodule

module addr_decoder_chk #(
  parameter int RAM_KB    = 32,
  parameter int SCREEN_KB = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        wr,
  input logic [7:0]  rdata,
  input logic        cs_ram,
  input logic        cs_scr,
  input logic        cs_exp,
  input logic        cs_basic,
  input logic        cs_edit,
  input logic        cs_kern,
  input logic        cs_port0,
  input logic        cs_port1,
  input logic        cs_tmr,
  input logic        cs_vid,
  input logic [11:0] scr_addr
);
  localparam logic [16:0] RAM_TOP = 17'(RAM_KB * 1024);
  localparam logic [12:0] SCR_TOP = 13'(SCREEN_KB * 1024);

  // R1
  mem_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_ram, cs_scr, cs_exp, cs_basic, cs_edit, cs_kern}));
  // R8
  rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !(cs_exp || cs_basic || cs_edit || cs_kern));
  // R2
  ram_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_ram |-> ({1'b0, addr} < RAM_TOP));
  // R3
  scr_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_scr |-> ({1'b0, scr_addr} < SCR_TOP && scr_addr[9:0] == addr[9:0]));
  // R4
  port_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_port0 || cs_port1 || cs_tmr || cs_vid) |->
      (addr[15:11] == 5'b11101 && (!cs_port0 || addr[4]) && (!cs_port1 || addr[5])
       && (!cs_tmr || addr[6]) && (!cs_vid || addr[7])));
  // R6
  open_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:11] == 5'b11101 && !wr && !cs_edit &&
     !(cs_port0 || cs_port1 || cs_tmr || cs_vid)) |-> rdata == 8'hFF);
endmodule

bind addr_decoder addr_decoder_chk #(.RAM_KB(RAM_KB), .SCREEN_KB(SCREEN_KB)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rdata(rdata),
  .cs_ram(cs_ram), .cs_scr(cs_scr), .cs_exp(cs_exp), .cs_basic(cs_basic),
  .cs_edit(cs_edit), .cs_kern(cs_kern), .cs_port0(cs_port0), .cs_port1(cs_port1),
  .cs_tmr(cs_tmr), .cs_vid(cs_vid), .scr_addr(scr_addr));

// File: tb/test_addr_decoder.sv
module test_addr_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic wr = 1'b0;
  logic [7:0] wdata = 8'h0, mem_rdata = 8'h5A;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  logic [7:0] rdA, rdB;
  logic [9:0] csA, csB;
  logic [14:0] raA, raB;
  logic [11:0] saA, saB;

  addr_decoder #(.RAM_KB(16), .SCREEN_KB(1), .IO_PAGE_ONLY(1'b1), .HAS_VIDEO(1'b1)) i_addr_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .mem_rdata(mem_rdata),
    .rdata(rdA), .cs_ram(csA[9]), .cs_scr(csA[8]), .cs_exp(csA[7]), .cs_basic(csA[6]),
    .cs_edit(csA[5]), .cs_kern(csA[4]), .cs_port0(csA[3]), .cs_port1(csA[2]),
    .cs_tmr(csA[1]), .cs_vid(csA[0]), .ram_addr(raA), .scr_addr(saA));

  addr_decoder #(.RAM_KB(32), .SCREEN_KB(2), .IO_PAGE_ONLY(1'b0), .HAS_VIDEO(1'b0)) i_addr_decoder_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .mem_rdata(mem_rdata),
    .rdata(rdB), .cs_ram(csB[9]), .cs_scr(csB[8]), .cs_exp(csB[7]), .cs_basic(csB[6]),
    .cs_edit(csB[5]), .cs_kern(csB[4]), .cs_port0(csB[3]), .cs_port1(csB[2]),
    .cs_tmr(csB[1]), .cs_vid(csB[0]), .ram_addr(raB), .scr_addr(saB));

  // {addr, wr, selects ram..vid, rdata} for the first copy after reset
  localparam int NV = 21;
  localparam logic [34:0] VEC [NV] = '{
    {16'h0000, 1'b0, 10'b1000000000, 8'h5A},
    {16'h3FFF, 1'b0, 10'b1000000000, 8'h5A},
    {16'h4000, 1'b0, 10'b0000000000, 8'hFF},
    {16'h8000, 1'b0, 10'b0100000000, 8'h5A},
    {16'h9000, 1'b0, 10'b0010000000, 8'h5A},
    {16'hBFFF, 1'b0, 10'b0010000000, 8'h5A},
    {16'hC000, 1'b0, 10'b0001000000, 8'h5A},
    {16'hE000, 1'b0, 10'b0000100000, 8'h5A},
    {16'hE7FF, 1'b0, 10'b0000100000, 8'h5A},
    {16'hE810, 1'b0, 10'b0000001000, 8'h00},
    {16'hE820, 1'b0, 10'b0000000100, 8'h00},
    {16'hE840, 1'b0, 10'b0000000010, 8'h00},
    {16'hE880, 1'b0, 10'b0000000001, 8'h00},
    {16'hE8F0, 1'b0, 10'b0000001111, 8'h00},
    {16'hE800, 1'b0, 10'b0000000000, 8'hFF},
    {16'hE910, 1'b0, 10'b0000100000, 8'h5A},
    {16'hF000, 1'b0, 10'b0000010000, 8'h5A},
    {16'hF000, 1'b1, 10'b0000000000, 8'h5A},
    {16'hC000, 1'b1, 10'b0000000000, 8'h5A},
    {16'h8000, 1'b1, 10'b0100000000, 8'h5A},
    {16'h1000, 1'b1, 10'b1000000000, 8'h5A}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic w);
    @(negedge clk);
    addr = a; wr = w;
    #2;
  endtask

  task automatic write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    #2;
  endtask

  initial begin
    #200us;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state of a port register
    put(16'hE81F, 1'b0);
    check("R9 reset", {8'h0, rdA}, 16'h0000);

    // R1 R2 R6 R8 R11 R4 R7 table
    for (int i = 0; i < NV; i++) begin
      put(VEC[i][34:19], VEC[i][18]);
      check($sformatf("R1/R4/R7/R8 selects vec %0d", i), {6'h0, csA}, {6'h0, VEC[i][17:8]});
      if (!VEC[i][18])
        check($sformatf("R2/R5/R6/R11 rdata vec %0d", i), {8'h0, rdA}, {8'h0, VEC[i][7:0]});
    end
    put(16'h0000, 1'b0);

    // R5 overlap AND
    write(16'hE811, 8'hF3);
    write(16'hE821, 8'h3F);
    put(16'hE811, 1'b0);
    check("R9 port0 readback", {8'h0, rdA}, 16'h00F3);
    put(16'hE831, 1'b0);
    check("R5 overlap AND", {8'h0, rdA}, 16'h0033);
    check("R5 overlap selects", {6'h0, csA}, 16'h000C);

    // R10 video index/data
    write(16'hE880, 8'h05);
    write(16'hE881, 8'hAB);
    put(16'hE889, 1'b0);
    check("R10 data reg mirror", {8'h0, rdA}, 16'h00AB);
    put(16'hE888, 1'b0);
    check("R10 index reg", {8'h0, rdA}, 16'h0005);
    write(16'hE880, 8'h06);
    put(16'hE881, 1'b0);
    check("R10 other entry", {8'h0, rdA}, 16'h0000);

    // R10 absent controller on second copy
    put(16'hE880, 1'b0);
    check("R10 absent select", {15'h0, csB[0]}, 16'h0000);
    check("R10 absent rdata", {8'h0, rdB}, 16'h00FF);

    // R7 full window on second copy, page-only on first
    write(16'hE811, 8'h77);
    put(16'hEF11, 1'b0);
    check("R7/R9 full window mirror", {8'h0, rdB}, 16'h0077);
    check("R7 full window select", {6'h0, csB}, 16'h0008);
    check("R7 page-only editor", {6'h0, csA}, 16'h0020);

    // R2 top of 32K
    put(16'h7FFF, 1'b0);
    check("R2 32K top", {15'h0, csB[9]}, 16'h0001);
    check("R2 16K hole", {8'h0, rdA}, 16'h00FF);
    check("R11 pass-through", {8'h0, rdB}, 16'h005A);

    // R3 screen mirror
    put(16'h8C05, 1'b0);
    check("R3 1K mirror", {4'h0, saA}, 16'h0005);
    check("R3 2K mirror", {4'h0, saB}, 16'h0405);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule